// File: doc/BRIEF.md
# Synchronous Burst Static Memory with Byte-Lane Writes

This block is a single-port synchronous static memory whose words are split into four 9-bit byte lanes (8 data bits and a parity bit each). Each rising clock edge samples every control, address and data input. A cycle opens with one of two address strobes. One is meant for a processor and only ever reads. The other is meant for a memory controller and may read or write. Once a cycle has been opened, a 2-bit counter inside the block produces the following burst addresses, one step for each cycle in which the advance input is low.

The depth is `2**AW` words. `AW = 15` gives the full 32768-word array. The default `AW` is 10 so that the default build stays small. A write can cover any subset of the lanes. A global-write input overrides the lane controls. Read data is registered one clock after the access, so data written in one cycle is returned by a read of the same address in the next cycle. The output enable gates the read bus with no clock involved. `rdata_oe` is the pad drive enable; when it is low the pad ring floats the bus and `rdata_o` is held at zero. A sleep input freezes the block: no access starts, contents and burst state are kept, and the bus is released.

Top module: `sync_burst_sram`

## Requirements
- R1: Each of the `2**AW` words holds 36 bits as lanes 0 to 3. Lane i occupies bits 9*i+8 down to 9*i. A full-word write followed by a read returns all 36 bits, including at word 0 and at the last word.
- R2: A strobe load selects the device only when `chip_en_n` is 0, `exp_en` is 1 and `exp_en_n` is 0, all sampled at that load. A deselected load performs no read and no write, and the bus stays released until the next selected load.
- R3: The burst address keeps the upper bits of the loaded address. Its two low bits are `start + n` modulo 4 when `burst_order` is 0 (linear), and `start XOR n` when `burst_order` is 1 (interleaved). Here n counts the cycles with `adv_n` low since the load. A cycle with `adv_n` high and no strobe accesses the same address again.
- R4: When `glob_we_n` is 1, lane i is written only if `lane_we_n[i]` is 0 and `byte_we_n` is 0. When `byte_we_n` is 1, the lane inputs are ignored and the cycle is a read.
- R5: When `glob_we_n` is 0, all four lanes are written, whatever `byte_we_n` and `lane_we_n` hold.
- R6: A load by `cpu_strobe_n` is always a read, even with write inputs active. `cpu_strobe_n` is ignored while `chip_en_n` is 1, and a burst already in progress then continues.
- R7: `rdata_oe` is 0 and `rdata_o` is 0 whenever `out_en_n` is 1. The effect follows `out_en_n` without waiting for a clock edge.
- R8: While `sleep` is 1, no load, read or write takes place, the bus is released at once, and the burst state and memory contents are kept for the cycles after `sleep` returns to 0.
- R9: Read data is driven from the edge that samples the read until the next edge. A write cycle drives nothing. A read of the word written in the previous cycle returns the new data.
- R10: During reset and after reset, before any selected load, the bus is released and no access takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state |
| addr_i | input | AW | Word address |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| chip_en_n | input | 1 | Primary select, active low |
| exp_en | input | 1 | Depth-expansion select, active high |
| exp_en_n | input | 1 | Depth-expansion select, active low |
| cpu_strobe_n | input | 1 | Read-only address strobe, active low |
| ctl_strobe_n | input | 1 | Read/write address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| lane_we_n | input | 4 | Per-lane write select, active low |
| byte_we_n | input | 1 | Qualifier for the lane selects, active low |
| glob_we_n | input | 1 | Write all lanes, active low |
| burst_order | input | 1 | 0 linear, 1 interleaved |
| out_en_n | input | 1 | Output enable, active low, combinational |
| sleep | input | 1 | Freeze accesses and release the bus |
| rdata_o | output | 36 | Read data, zero when not driven |
| rdata_oe | output | 1 | Pad drive enable for rdata_o |

## Verification
The hardest situation to reach from the ports is an access that is suppressed while a burst is active. Two cases matter: a processor strobe that arrives while the primary select is high, and a controller write that is presented during sleep. In both, the bus must show the word of the burst already in progress, not the new address. The bench first opens a burst on one word and checks what it reads. It then applies the suppressed request with a different address and data, and checks that the next data phase still returns the first word. A later read confirms that the target of the suppressed write kept its old contents.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_ord_e;

  // low two address bits for burst step n from a loaded start
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input burst_ord_e ord);
    return (ord == ORD_INTERLEAVE) ? (start ^ step) : (start + step);
  endfunction

  // lane write selection before the cycle-type qualification
  function automatic logic lane_pick(input logic lane_n,
                                     input logic byte_n,
                                     input logic glob_n);
    return !glob_n || (!byte_n && !lane_n);
  endfunction

endpackage

// File: rtl/sbs_addr_seq.sv
module sbs_addr_seq
  import sbs_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          load,
  input  logic          sel_now,
  input  logic          adv_n,
  input  logic          order,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] eff_addr,
  output logic          act_now
);
  localparam int HI_W = AW - 2;

  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic [1:0]    step;
  logic          act_q;
  burst_ord_e    ord;

  assign ord = burst_ord_e'(order);

  always_comb begin
    if (load) begin
      step     = 2'd0;
      eff_addr = addr;
      act_now  = sel_now;
    end else begin
      step     = adv_n ? cnt_q : cnt_q + 2'd1;
      eff_addr = {base_q[AW-1 -: HI_W], burst_low(base_q[1:0], step, ord)};
      act_now  = act_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
      act_q  <= 1'b0;
    end else if (!hold) begin
      cnt_q <= step;
      if (load) begin
        base_q <= addr;
        act_q  <= sel_now;
      end
    end
  end

endmodule

// File: rtl/sbs_lane_dec.sv
module sbs_lane_dec
  import sbs_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] lane_we_n,
  input  logic             byte_we_n,
  input  logic             glob_we_n,
  output logic [LANES-1:0] lane_sel
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_sel[g] = lane_pick(lane_we_n[g], byte_we_n, glob_we_n);
  end
endmodule

// File: rtl/sbs_lane_ram.sv
module sbs_lane_ram #(
  parameter int AW     = 10,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              wr,
  input  logic              rd,
  input  logic [AW-1:0]     addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[addr] <= wdata;
    if (rd) rdata <= mem[addr];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int AW     = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             chip_en_n,
  input  logic             exp_en,
  input  logic             exp_en_n,
  input  logic             cpu_strobe_n,
  input  logic             ctl_strobe_n,
  input  logic             adv_n,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             byte_we_n,
  input  logic             glob_we_n,
  input  logic             burst_order,
  input  logic             out_en_n,
  input  logic             sleep,
  output logic [DW-1:0]    rdata_o,
  output logic             rdata_oe
);
  // named internal events
  logic             sel_now;
  logic             p_load;
  logic             c_load;
  logic             load_evt;
  logic             act_now;
  logic             acc_evt;
  logic             wr_evt;
  logic             rd_evt;
  logic [LANES-1:0] lane_sel;
  logic [LANES-1:0] lane_wr;
  logic [AW-1:0]    eff_addr;
  logic [DW-1:0]    ram_q;
  logic             q_vld;

  assign sel_now  = !chip_en_n && exp_en && !exp_en_n;
  assign p_load   = !cpu_strobe_n && !chip_en_n;
  assign c_load   = !ctl_strobe_n;
  assign load_evt = !sleep && (p_load || c_load);

  sbs_addr_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (sleep),
    .load     (load_evt),
    .sel_now  (sel_now),
    .adv_n    (adv_n),
    .order    (burst_order),
    .addr     (addr_i),
    .eff_addr (eff_addr),
    .act_now  (act_now)
  );

  sbs_lane_dec #(.LANES(LANES)) u_dec (
    .lane_we_n (lane_we_n),
    .byte_we_n (byte_we_n),
    .glob_we_n (glob_we_n),
    .lane_sel  (lane_sel)
  );

  assign acc_evt = !sleep && act_now;
  // a processor-strobe load is forced to a read
  assign wr_evt  = acc_evt && !(load_evt && p_load) && (|lane_sel);
  assign rd_evt  = acc_evt && !wr_evt;
  assign lane_wr = lane_sel & {LANES{wr_evt}};

  for (genvar g = 0; g < LANES; g++) begin : g_ram
    sbs_lane_ram #(.AW(AW), .LANE_W(LANE_W)) u_ram (
      .clk   (clk),
      .wr    (lane_wr[g]),
      .rd    (rd_evt),
      .addr  (eff_addr),
      .wdata (wdata_i[g*LANE_W +: LANE_W]),
      .rdata (ram_q[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_vld <= 1'b0;
    else        q_vld <= rd_evt;
  end

  assign rdata_oe = q_vld && !out_en_n && !sleep;
  assign rdata_o  = rdata_oe ? ram_q : '0;

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int AW    = 10,
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep,
  input logic             out_en_n,
  input logic             byte_we_n,
  input logic             glob_we_n,
  input logic             rdata_oe,
  input logic             p_load,
  input logic             load_evt,
  input logic             acc_evt,
  input logic             wr_evt,
  input logic [LANES-1:0] lane_wr,
  input logic [AW-1:0]    eff_addr
);
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!rdata_oe && !acc_evt && !wr_evt)); // R8

  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !rdata_oe); // R7

  AST_CPU_LOAD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && p_load) |-> !wr_evt); // R6

  AST_LANES_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we_n && glob_we_n) |-> (lane_wr == '0)); // R4

  AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !glob_we_n) |-> (&lane_wr)); // R5

  AST_BURST_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && !load_evt && $past(acc_evt))
      |-> (eff_addr[AW-1:2] == $past(eff_addr[AW-1:2]))); // R3
endmodule

bind sync_burst_sram sbs_checker #(.AW(AW), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sleep     (sleep),
  .out_en_n  (out_en_n),
  .byte_we_n (byte_we_n),
  .glob_we_n (glob_we_n),
  .rdata_oe  (rdata_oe),
  .p_load    (p_load),
  .load_evt  (load_evt),
  .acc_evt   (acc_evt),
  .wr_evt    (wr_evt),
  .lane_wr   (lane_wr),
  .eff_addr  (eff_addr)
);

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;
  localparam int AW = 10;
  localparam int LANES = 4;
  localparam int LW = 9;
  localparam int DW = LANES * LW;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] wdata_i;
  logic          chip_en_n, exp_en, exp_en_n;
  logic          cpu_strobe_n, ctl_strobe_n, adv_n;
  logic [3:0]    lane_we_n;
  logic          byte_we_n, glob_we_n, burst_order, out_en_n, sleep;
  logic [DW-1:0] rdata_o;
  logic          rdata_oe;

  sync_burst_sram #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
    .chip_en_n(chip_en_n), .exp_en(exp_en), .exp_en_n(exp_en_n),
    .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n), .adv_n(adv_n),
    .lane_we_n(lane_we_n), .byte_we_n(byte_we_n), .glob_we_n(glob_we_n),
    .burst_order(burst_order), .out_en_n(out_en_n), .sleep(sleep),
    .rdata_o(rdata_o), .rdata_oe(rdata_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // vector table: {lane_we_n[3:0], byte_we_n, glob_we_n, expected lane mask[3:0]}
  localparam logic [9:0] VTAB [7] = '{
    {4'b1110, 1'b0, 1'b1, 4'b0001},
    {4'b0101, 1'b0, 1'b1, 4'b1010},
    {4'b0000, 1'b1, 1'b1, 4'b0000},
    {4'b0000, 1'b0, 1'b1, 4'b1111},
    {4'b1111, 1'b1, 1'b0, 4'b1111},
    {4'b0110, 1'b1, 1'b0, 4'b1111},
    {4'b1111, 1'b0, 1'b1, 4'b0000}
  };

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return (36'(a) * 36'h0_0001_0003) ^ (36'(salt) << 20) ^ 36'h9_6C3A_5A1E;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cpu_strobe_n = 1'b1; ctl_strobe_n = 1'b1; adv_n = 1'b1;
    lane_we_n = 4'hF; byte_we_n = 1'b1; glob_we_n = 1'b1;
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d,
                    input logic [3:0] lwn, input logic bwn, input logic gwn);
    addr_i = AW'(a); wdata_i = d; ctl_strobe_n = 1'b0;
    lane_we_n = lwn; byte_we_n = bwn; glob_we_n = gwn;
    tick();
    idle();
  endtask

  task automatic rd(input int a);
    addr_i = AW'(a); ctl_strobe_n = 1'b0;
    tick();
    idle();
  endtask

  initial begin
    logic [DW-1:0] oldw, neww, expw;
    rst_n = 1'b0; addr_i = '0; wdata_i = '0;
    chip_en_n = 1'b0; exp_en = 1'b1; exp_en_n = 1'b0;
    burst_order = 1'b0; out_en_n = 1'b0; sleep = 1'b0;
    idle();
    repeat (3) tick();
    chk("R10 reset bus released", DW'(rdata_oe), '0);
    chk("R10 reset data zero", rdata_o, '0);
    rst_n = 1'b1;
    repeat (2) tick();
    chk("R10 no access before load", DW'(rdata_oe), '0);

    // R1 full-width words at both ends of the array
    wr(0, pat(0, 11), 4'hF, 1'b1, 1'b0);
    wr((1 << AW) - 1, pat((1 << AW) - 1, 11), 4'hF, 1'b1, 1'b0);
    rd(0);
    chk("R1 word 0", rdata_o, pat(0, 11));
    rd((1 << AW) - 1);
    chk("R1 last word", rdata_o, pat((1 << AW) - 1, 11));

    // R4 / R5 table of lane-write controls
    for (int i = 0; i < 7; i++) begin
      oldw = pat(32 + i, 1);
      neww = pat(32 + i, 2);
      wr(32 + i, oldw, 4'hF, 1'b1, 1'b0);
      wr(32 + i, neww, VTAB[i][9:6], VTAB[i][5], VTAB[i][4]);
      for (int l = 0; l < LANES; l++)
        expw[l*LW +: LW] = VTAB[i][l] ? neww[l*LW +: LW] : oldw[l*LW +: LW];
      rd(32 + i);
      chk(VTAB[i][4] ? "R4 lane write merge" : "R5 global write", rdata_o, expw);
    end

    // R9 write drives nothing, then pass-through read
    wr(90, pat(90, 3), 4'hF, 1'b1, 1'b0);
    chk("R9 write cycle undriven", DW'(rdata_oe), '0);
    rd(90);
    chk("R9 pass-through", rdata_o, pat(90, 3));
    chk("R9 driven after read", DW'(rdata_oe), DW'(1));

    // R7 output enable without a clock edge
    out_en_n = 1'b1; #2;
    chk("R7 oe high releases", DW'(rdata_oe), '0);
    chk("R7 oe high data zero", rdata_o, '0);
    out_en_n = 1'b0; #2;
    chk("R7 oe low drives", rdata_o, pat(90, 3));

    // R3 bursts
    for (int k = 0; k < 4; k++) wr(64 + k, pat(64 + k, 3), 4'hF, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) wr(1020 + k, pat(1020 + k, 3), 4'hF, 1'b1, 1'b0);
    burst_order = 1'b0;
    rd(65);
    chk("R3 linear start", rdata_o, pat(65, 3));
    adv_n = 1'b0;
    for (int s = 1; s <= 3; s++) begin
      tick();
      chk("R3 linear step", rdata_o, pat(64 + ((1 + s) % 4), 3));
    end
    adv_n = 1'b1;
    tick();
    chk("R3 adv high holds address", rdata_o, pat(64, 3));
    burst_order = 1'b1;
    rd(65);
    adv_n = 1'b0;
    for (int s = 1; s <= 3; s++) begin
      tick();
      chk("R3 interleaved step", rdata_o, pat(64 + (1 ^ s), 3));
    end
    adv_n = 1'b1;
    burst_order = 1'b0;
    rd(1023);
    adv_n = 1'b0;
    tick();
    chk("R3 wrap keeps upper bits", rdata_o, pat(1020, 3));
    adv_n = 1'b1;

    // R2 depth-expansion and primary selects
    wr(100, pat(100, 4), 4'hF, 1'b1, 1'b0);
    exp_en = 1'b0;
    rd(100);
    chk("R2 exp_en low deselects", DW'(rdata_oe), '0);
    exp_en = 1'b1; exp_en_n = 1'b1;
    wr(100, pat(100, 5), 4'hF, 1'b1, 1'b0);
    exp_en_n = 1'b0; chip_en_n = 1'b1;
    wr(100, pat(100, 6), 4'hF, 1'b1, 1'b0);
    chk("R2 stays released when deselected", DW'(rdata_oe), '0);
    chip_en_n = 1'b0;
    rd(100);
    chk("R2 deselected writes dropped", rdata_o, pat(100, 4));

    // R6 processor strobe is read-only and needs the primary select
    wr(110, pat(110, 7), 4'hF, 1'b1, 1'b0);
    addr_i = AW'(110); wdata_i = pat(110, 8); cpu_strobe_n = 1'b0; glob_we_n = 1'b0;
    tick(); idle();
    chk("R6 cpu strobe reads", rdata_o, pat(110, 7));
    rd(110);
    chk("R6 cpu strobe wrote nothing", rdata_o, pat(110, 7));
    addr_i = AW'(64); chip_en_n = 1'b1; cpu_strobe_n = 1'b0;
    tick(); idle(); chip_en_n = 1'b0;
    chk("R6 cpu strobe ignored, burst continues", rdata_o, pat(110, 7));

    // R8 sleep
    wr(120, pat(120, 1), 4'hF, 1'b1, 1'b0);
    rd(64);
    sleep = 1'b1; #2;
    chk("R8 sleep releases bus at once", DW'(rdata_oe), '0);
    addr_i = AW'(120); wdata_i = pat(120, 9); ctl_strobe_n = 1'b0; glob_we_n = 1'b0;
    tick(); idle();
    chk("R8 no drive during sleep", DW'(rdata_oe), '0);
    tick();
    sleep = 1'b0;
    tick();
    chk("R8 burst state kept", rdata_o, pat(64, 3));
    rd(120);
    chk("R8 write during sleep dropped", rdata_o, pat(120, 1));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R10 actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule